// File: doc/BRIEF.md
# Match-Capture Timer/Counter

A counting peripheral with a word-addressed register port. The counter advances either on ticks of a programmable clock divider or on selected edges of one of two external input pins. Four compare channels watch the counter. On a hit, each channel can raise an interrupt flag, send the counter back to zero, or halt it. Each channel also drives an output pin through a two-bit action. Two capture channels take a snapshot of the counter on chosen edges of their pins. Every event flag sits in one flag register, which software clears by writing ones, and a single interrupt line is the OR of all flags.

Software sets the divider, the compare values and the per-channel actions, then sets the run bit. A compare hit that halts the counter clears the run bit itself. Capture pins are asynchronous: each passes through two flops before its edges are detected, so a pin change takes effect on the third rising clock edge after it. Registers are addressed by word index: run control 0, counter 1, divider limit 2, divider count 3, flags 4, compare control 5, compare values 6 to 9, capture control 10, capture values 11 to 12, pin control 13, count source 14. Any other index reads zero.

Top module: `mc_timer`

## Requirements
- R1: After reset every register reads zero, mat_o is 0 and irq_o is low.
- R2: In run control (index 0), bit 0 enables counting and bit 1 holds both the counter and the divider count at zero. Only these two bits are stored.
- R3: In count-source mode 0, the divider count (index 3) steps from 0 up to the divider limit (index 2) and then wraps to 0. The counter steps by one on the clock in which the divider wraps, so it steps every limit+1 cycles.
- R4: A compare channel n hits when the counter equals compare value n at the moment the counter would step. Compare control bit 3n then sets flag n. Bit 3n+1 makes the counter go to 0 instead of stepping. Bit 3n+2 clears run bit 0 and leaves the counter unchanged. When bits 3n+1 and 3n+2 both act, the counter goes to 0.
- R5: Pin control bit n is the level of mat_o[n]. The field at bits 4+2n..5+2n picks the action on a hit of channel n: 0 none, 1 drive low, 2 drive high, 3 toggle. A hit wins over a same-cycle software write of that level bit.
- R6: Flag bits 0..3 are compare flags and bits 4..5 are capture flags. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A flag set in the same cycle as a clear stays set. irq_o is high when any flag is set.
- R7: Count-source bits 1:0 pick the counting mode: 0 divided clock, 1 rising edges, 2 falling edges, 3 both edges. Bit 2 picks the counting pin (0 = cap_i[0], 1 = cap_i[1]). In modes 1 to 3 the divider count is held at 0, and edges on the other pin do not move the counter.
- R8: Capture control bit 3n captures on rising edges of cap_i[n] and bit 3n+1 captures on falling edges. On such an edge, capture value n loads the counter value, whether or not counting is enabled. If bit 3n+2 is also set, flag 4+n is set.
- R9: A change on cap_i takes effect, as a capture or a count, on the third rising clock edge after the change.
- R10: A software write to the counter or to the divider count wins over a same-cycle step. Compare control keeps 12 bits, capture control 6, pin control 12 and count source 4.
- R11: The counter wraps from 2^CNT_W-1 to 0 when it steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable (with sel_i) |
| addr_i | input | 6 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| cap_i | input | 2 | Asynchronous capture / count pins |
| mat_o | output | 4 | Compare output pins |
| irq_o | output | 1 | OR of all flags |

## Verification
The bench builds the block with CNT_W = 8. This brings wraparound of the counter and of the divider within a few cycles, and lets compare values, captured values and the stop point be checked at full width. The bench runs a behavioural model next to the design and compares rdata_o at the current index, mat_o and irq_o on every clock. It covers divided counting with reset-on-hit and toggling, stop-on-hit, counting on each edge kind of the selected pin, captures while enabled and disabled, and flag clear racing flag set. Direct checks pin down the three-edge pin latency, the readback widths and the wrap from 0xFF to 0.

// File: rtl/mc_timer_pkg.sv
package mc_timer_pkg;
  localparam int N_MATCH = 4;
  localparam int N_CAP   = 2;
  localparam int ADDR_W  = 6;
  localparam int EMR_W   = 4 + 2 * N_MATCH;
  localparam int MCR_W   = 3 * N_MATCH;
  localparam int CCR_W   = 3 * N_CAP;
  localparam int IR_W    = N_MATCH + N_CAP;

  typedef enum logic [1:0] {PIN_HOLD, PIN_LOW, PIN_HIGH, PIN_TOGGLE} pin_act_e;
  typedef enum logic [1:0] {CM_TIMER, CM_RISE, CM_FALL, CM_BOTH} cnt_mode_e;

  localparam logic [ADDR_W-1:0] IDX_CTRL = 6'd0;
  localparam logic [ADDR_W-1:0] IDX_TC   = 6'd1;
  localparam logic [ADDR_W-1:0] IDX_PR   = 6'd2;
  localparam logic [ADDR_W-1:0] IDX_PC   = 6'd3;
  localparam logic [ADDR_W-1:0] IDX_IR   = 6'd4;
  localparam logic [ADDR_W-1:0] IDX_MCR  = 6'd5;
  localparam logic [ADDR_W-1:0] IDX_MR0  = 6'd6;
  localparam logic [ADDR_W-1:0] IDX_CCR  = 6'd10;
  localparam logic [ADDR_W-1:0] IDX_CR0  = 6'd11;
  localparam logic [ADDR_W-1:0] IDX_EMR  = 6'd13;
  localparam logic [ADDR_W-1:0] IDX_CTCR = 6'd14;
endpackage

// File: rtl/mc_edge_sync.sv
module mc_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // [0],[1] synchronizer, [2] history for edge detect
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], pin_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
  assign fall_o = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/mc_prescaler.sv
module mc_prescaler #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] pc_o,
  output logic         tick_o
);
  logic [W-1:0] pc_q;

  assign tick_o = run_i && (pc_q == limit_i);
  assign pc_o   = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (clr_i)  pc_q <= '0;
    else if (wr_i)   pc_q <= wdata_i;
    else if (run_i)  pc_q <= tick_o ? '0 : pc_q + W'(1);
  end

  // R2
  pc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pc_q == '0));
endmodule

// File: rtl/mc_match_ch.sv
module mc_match_ch
  import mc_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic     [W-1:0] tc_i,
  input  logic     [W-1:0] mr_i,
  input  logic             inc_i,
  input  logic     [2:0]   cfg_i,   // {stop, reset, int}
  input  pin_act_e         act_i,
  input  logic             lvl_i,
  output logic             hit_o,
  output logic             flag_o,
  output logic             rst_o,
  output logic             stop_o,
  output logic             lvl_o
);
  assign hit_o  = inc_i && (tc_i == mr_i);
  assign flag_o = hit_o & cfg_i[0];
  assign rst_o  = hit_o & cfg_i[1];
  assign stop_o = hit_o & cfg_i[2];

  always_comb begin
    lvl_o = lvl_i;
    if (hit_o) begin
      unique case (act_i)
        PIN_LOW:    lvl_o = 1'b0;
        PIN_HIGH:   lvl_o = 1'b1;
        PIN_TOGGLE: lvl_o = ~lvl_i;
        default:    lvl_o = lvl_i;
      endcase
    end
  end
endmodule

// File: rtl/mc_timer.sv
module mc_timer
  import mc_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_CAP-1:0]  cap_i,
  output logic [N_MATCH-1:0] mat_o,
  output logic              irq_o
);
  logic [1:0]        ctrl_q;
  logic [CNT_W-1:0]  tc_q, pr_q, pc;
  logic [IR_W-1:0]   ir_q;
  logic [MCR_W-1:0]  mcr_q;
  logic [CNT_W-1:0]  mr_q [N_MATCH];
  logic [CCR_W-1:0]  ccr_q;
  logic [CNT_W-1:0]  cr_q [N_CAP];
  logic [EMR_W-1:0]  emr_q, emr_base;
  logic [3:0]        ctcr_q;

  logic wr;
  assign wr = sel_i & we_i;

  logic hold, run_en, timer_mode, tick, cnt_edge, inc;
  cnt_mode_e mode;
  logic src;
  assign hold       = ctrl_q[1];
  assign run_en     = ctrl_q[0] & ~hold;
  assign mode       = cnt_mode_e'(ctcr_q[1:0]);
  assign src        = ctcr_q[2];
  assign timer_mode = (mode == CM_TIMER);

  logic [N_CAP-1:0] rise, fall, cap_evt, cap_flag;
  for (genvar c = 0; c < N_CAP; c++) begin : g_cap
    mc_edge_sync u_sync (.clk_i, .rst_ni, .pin_i(cap_i[c]), .rise_o(rise[c]), .fall_o(fall[c]));
    assign cap_evt[c]  = (ccr_q[3*c] & rise[c]) | (ccr_q[3*c+1] & fall[c]);
    assign cap_flag[c] = cap_evt[c] & ccr_q[3*c+2];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cr_q[c] <= '0;
      else if (cap_evt[c]) cr_q[c] <= tc_q;
    end
    // R8
    cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_evt[c] |=> (cr_q[c] == $past(tc_q)));
  end

  always_comb begin
    unique case (mode)
      CM_RISE: cnt_edge = rise[src];
      CM_FALL: cnt_edge = fall[src];
      CM_BOTH: cnt_edge = rise[src] | fall[src];
      default: cnt_edge = 1'b0;
    endcase
  end

  mc_prescaler #(.W(CNT_W)) u_pre (
    .clk_i, .rst_ni,
    .run_i  (run_en & timer_mode),
    .clr_i  (hold | ~timer_mode),
    .wr_i   (wr && addr_i == IDX_PC),
    .wdata_i(wdata_i[CNT_W-1:0]),
    .limit_i(pr_q),
    .pc_o   (pc),
    .tick_o (tick)
  );

  assign inc = timer_mode ? tick : (run_en & cnt_edge);

  assign emr_base = (wr && addr_i == IDX_EMR) ? wdata_i[EMR_W-1:0] : emr_q;

  logic [N_MATCH-1:0] hit, m_flag, m_rst, m_stop, lvl;
  pin_act_e act [N_MATCH];
  for (genvar n = 0; n < N_MATCH; n++) begin : g_match
    assign act[n] = pin_act_e'(emr_base[4+2*n +: 2]);
    mc_match_ch #(.W(CNT_W)) u_ch (
      .tc_i(tc_q), .mr_i(mr_q[n]), .inc_i(inc), .cfg_i(mcr_q[3*n +: 3]),
      .act_i(act[n]), .lvl_i(emr_base[n]),
      .hit_o(hit[n]), .flag_o(m_flag[n]), .rst_o(m_rst[n]), .stop_o(m_stop[n]), .lvl_o(lvl[n])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mr_q[n] <= '0;
      else if (wr && addr_i == IDX_MR0 + n)  mr_q[n] <= wdata_i[CNT_W-1:0];
    end
    // R5
    pin_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit[n] && act[n] == PIN_HIGH) |=> emr_q[n]);
  end

  logic any_rst, any_stop;
  assign any_rst  = |m_rst;
  assign any_stop = |m_stop;

  logic [IR_W-1:0] ir_clr;
  assign ir_clr = (wr && addr_i == IDX_IR) ? wdata_i[IR_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; tc_q <= '0; pr_q <= '0; ir_q <= '0;
      mcr_q <= '0; ccr_q <= '0; emr_q <= '0; ctcr_q <= '0;
    end else begin
      if (hold)                                tc_q <= '0;
      else if (wr && addr_i == IDX_TC)         tc_q <= wdata_i[CNT_W-1:0];
      else if (inc)                            tc_q <= any_rst ? '0 : (any_stop ? tc_q : tc_q + CNT_W'(1));
      ctrl_q[1] <= (wr && addr_i == IDX_CTRL) ? wdata_i[1] : ctrl_q[1];
      ctrl_q[0] <= ~any_stop & ((wr && addr_i == IDX_CTRL) ? wdata_i[0] : ctrl_q[0]);
      if (wr && addr_i == IDX_PR)   pr_q   <= wdata_i[CNT_W-1:0];
      if (wr && addr_i == IDX_MCR)  mcr_q  <= wdata_i[MCR_W-1:0];
      if (wr && addr_i == IDX_CCR)  ccr_q  <= wdata_i[CCR_W-1:0];
      if (wr && addr_i == IDX_CTCR) ctcr_q <= wdata_i[3:0];
      ir_q  <= (ir_q & ~ir_clr) | {cap_flag, m_flag};
      emr_q <= {emr_base[EMR_W-1:N_MATCH], lvl};
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i >= IDX_MR0 && addr_i < IDX_MR0 + N_MATCH)
      rdata_o = 32'(mr_q[addr_i - IDX_MR0]);
    else if (addr_i >= IDX_CR0 && addr_i < IDX_CR0 + N_CAP)
      rdata_o = 32'(cr_q[addr_i - IDX_CR0]);
    else begin
      unique case (addr_i)
        IDX_CTRL: rdata_o = 32'(ctrl_q);
        IDX_TC:   rdata_o = 32'(tc_q);
        IDX_PR:   rdata_o = 32'(pr_q);
        IDX_PC:   rdata_o = 32'(pc);
        IDX_IR:   rdata_o = 32'(ir_q);
        IDX_MCR:  rdata_o = 32'(mcr_q);
        IDX_CCR:  rdata_o = 32'(ccr_q);
        IDX_EMR:  rdata_o = 32'(emr_q);
        IDX_CTCR: rdata_o = 32'(ctcr_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign mat_o = emr_q[N_MATCH-1:0];
  assign irq_o = |ir_q;

  // R4
  stop_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stop |=> !ctrl_q[0]);
  // R3
  tc_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc && !hold && !(wr && addr_i == IDX_TC)) |=> $stable(tc_q));
  for (genvar b = 0; b < IR_W; b++) begin : g_irchk
    // R6
    flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ir_q[b] && !ir_clr[b]) |=> ir_q[b]);
  end
endmodule

// File: tb/mc_timer_tb_top.sv
module mc_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic sel = 0, we = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0] cap = 0;
  logic [3:0] mat;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0, live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_timer #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .mat_o(mat), .irq_o(irq)
  );

  // behavioural reference model
  logic [1:0] m_ctrl; logic [W-1:0] m_tc, m_pr, m_pc; logic [5:0] m_ir;
  logic [11:0] m_mcr, m_emr; logic [W-1:0] m_mr [4]; logic [5:0] m_ccr;
  logic [W-1:0] m_cr [2]; logic [3:0] m_ctcr;
  bit d1 [2], d2 [2], d3 [2];

  always @(posedge clk or negedge rst_n) begin : model
    int idx, mode, s;
    bit w, hold, tick, ev, inc, anyr, anys;
    bit r [2], f [2];
    logic [5:0] setf;
    logic [W-1:0] n_tc, n_pc;
    logic [1:0] n_ctrl; logic [11:0] n_emr;
    if (!rst_n) begin
      m_ctrl = 0; m_tc = 0; m_pr = 0; m_pc = 0; m_ir = 0; m_mcr = 0; m_emr = 0;
      m_ccr = 0; m_ctcr = 0;
      for (int i = 0; i < 4; i++) m_mr[i] = 0;
      for (int i = 0; i < 2; i++) begin m_cr[i] = 0; d1[i] = 0; d2[i] = 0; d3[i] = 0; end
    end else begin
      idx = addr; w = sel && we;
      for (int p = 0; p < 2; p++) begin r[p] = d2[p] && !d3[p]; f[p] = !d2[p] && d3[p]; end
      for (int p = 0; p < 2; p++) begin d3[p] = d2[p]; d2[p] = d1[p]; d1[p] = cap[p]; end
      hold = m_ctrl[1]; mode = m_ctcr[1:0]; s = m_ctcr[2];
      tick = (mode == 0) && m_ctrl[0] && !hold && (m_pc == m_pr);
      ev = (mode == 1) ? r[s] : (mode == 2) ? f[s] : (mode == 3) ? (r[s] || f[s]) : 0;
      inc = (mode == 0) ? tick : (m_ctrl[0] && !hold && ev);
      anyr = 0; anys = 0; setf = 0;
      n_emr = (w && idx == 13) ? wdata[11:0] : m_emr;
      for (int n = 0; n < 4; n++) begin
        if (inc && m_tc == m_mr[n]) begin
          if (m_mcr[3*n]) setf[n] = 1;
          if (m_mcr[3*n+1]) anyr = 1;
          if (m_mcr[3*n+2]) anys = 1;
          case (n_emr[4+2*n +: 2])
            2'd1: n_emr[n] = 0;
            2'd2: n_emr[n] = 1;
            2'd3: n_emr[n] = ~n_emr[n];
            default: ;
          endcase
        end
      end
      for (int c = 0; c < 2; c++)
        if ((m_ccr[3*c] && r[c]) || (m_ccr[3*c+1] && f[c])) begin
          m_cr[c] = m_tc;
          if (m_ccr[3*c+2]) setf[4+c] = 1;
        end
      n_tc = hold ? 0 : (w && idx == 1) ? wdata[W-1:0] :
             inc ? (anyr ? 0 : anys ? m_tc : W'(m_tc + 1)) : m_tc;
      n_pc = (hold || mode != 0) ? 0 : (w && idx == 3) ? wdata[W-1:0] :
             m_ctrl[0] ? ((m_pc == m_pr) ? 0 : W'(m_pc + 1)) : m_pc;
      n_ctrl = (w && idx == 0) ? wdata[1:0] : m_ctrl;
      if (anys) n_ctrl[0] = 0;
      m_ir = (m_ir & ~((w && idx == 4) ? wdata[5:0] : 6'd0)) | setf;
      if (w && idx == 2) m_pr = wdata[W-1:0];
      if (w && idx == 5) m_mcr = wdata[11:0];
      if (w && idx >= 6 && idx <= 9) m_mr[idx-6] = wdata[W-1:0];
      if (w && idx == 10) m_ccr = wdata[5:0];
      if (w && idx == 14) m_ctcr = wdata[3:0];
      m_tc = n_tc; m_pc = n_pc; m_ctrl = n_ctrl; m_emr = n_emr;
    end
  end

  function automatic logic [31:0] model_read(int idx);
    case (idx)
      0: return 32'(m_ctrl);  1: return 32'(m_tc);  2: return 32'(m_pr);
      3: return 32'(m_pc);    4: return 32'(m_ir);  5: return 32'(m_mcr);
      6, 7, 8, 9: return 32'(m_mr[idx-6]);
      10: return 32'(m_ccr);  11, 12: return 32'(m_cr[idx-11]);
      13: return 32'(m_emr);  14: return 32'(m_ctcr);
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int idx);
    if (idx == 0) return "R2";
    if (idx <= 3) return "R3";
    if (idx == 4) return "R6";
    if (idx <= 9) return "R4";
    if (idx <= 12) return "R8";
    if (idx == 13) return "R5";
    return "R7";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (live) begin
      chk(req_of(addr), rdata, model_read(addr));
      chk("R5", 32'(mat), 32'(m_emr[3:0]));
      chk("R6", 32'(irq), 32'(|m_ir));
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic wr_reg(int idx, logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = 6'(idx); wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(int idx, output logic [31:0] d);
    addr = 6'(idx); #2; d = rdata;
  endtask

  task automatic rd_chk(string req, int idx, logic [31:0] exp);
    logic [31:0] d;
    rd(idx, d); chk(req, d, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1); live = 1;
    // R1 reset state
    for (int i = 0; i < 16; i++) rd_chk("R1", i, 0);
    chk("R1", 32'(mat), 0); chk("R1", 32'(irq), 0);

    // R2 only two control bits, hold keeps counter at zero
    wr_reg(0, 32'hFFFF_FFFF); rd_chk("R2", 0, 3);
    cyc(5); rd_chk("R2", 1, 0); rd_chk("R2", 3, 0);

    // R10 readback widths
    wr_reg(5, 32'hFFFF_FFFF);  rd_chk("R10", 5, 32'hFFF);
    wr_reg(10, 32'hFFFF_FFFF); rd_chk("R10", 10, 32'h3F);
    wr_reg(14, 32'hFFFF_FFFF); rd_chk("R10", 14, 32'hF);
    wr_reg(13, 32'hFFFF_FFFF); rd_chk("R10", 13, 32'hFFF);
    chk("R5", 32'(mat), 32'hF);
    wr_reg(5, 0); wr_reg(10, 0); wr_reg(14, 0); wr_reg(13, 0);

    // R3 divided counting, R4 interrupt+reset on channel 0, R5 toggle
    wr_reg(2, 2); wr_reg(6, 3); wr_reg(5, 32'b011); wr_reg(13, 32'h30);
    wr_reg(0, 1);
    cyc(2); rd_chk("R3", 1, 0);
    cyc(1); rd_chk("R3", 1, 1);
    addr = 1; cyc(40);
    chk("R6", 32'(irq), 1);
    wr_reg(4, 32'h3F); addr = 4; cyc(20);
    wr_reg(0, 2); wr_reg(4, 32'h3F);

    // R4 stop on channel 1, R5 drive high
    wr_reg(5, 32'h20); wr_reg(7, 5); wr_reg(2, 0); wr_reg(13, 32'h80);
    wr_reg(0, 1); addr = 1; cyc(20);
    rd_chk("R4", 0, 0); rd_chk("R4", 1, 5); chk("R5", 32'(mat[1]), 1);

    // R11 wrap, R10 write beats step
    wr_reg(0, 2); wr_reg(5, 0); wr_reg(0, 1);
    wr_reg(1, 32'hFF); rd_chk("R10", 1, 32'hFF);
    cyc(1); rd_chk("R11", 1, 0);

    // R7 / R9 counting rising edges of pin 1
    wr_reg(0, 2); wr_reg(14, 32'b0101); wr_reg(0, 1);
    addr = 1;
    @(negedge clk); cap[1] = 1;
    cyc(1); rd_chk("R9", 1, 0);
    cyc(1); rd_chk("R9", 1, 0);
    cyc(1); rd_chk("R9", 1, 1);
    rd_chk("R7", 3, 0);
    for (int i = 0; i < 4; i++) begin cap[0] = ~cap[0]; cyc(4); end
    rd_chk("R7", 1, 1);
    wr_reg(14, 32'b0111);
    for (int i = 0; i < 4; i++) begin cap[1] = ~cap[1]; cyc(4); end
    rd_chk("R7", 1, 5);
    wr_reg(14, 32'b0110);
    for (int i = 0; i < 6; i++) begin cap[1] = ~cap[1]; addr = 1; cyc(3); end
    wr_reg(14, 32'b0011);
    for (int i = 0; i < 6; i++) begin cap[0] = ~cap[0]; addr = 1; cyc(3); end

    // R8 capture with and without counting, R6 flag race
    wr_reg(0, 2); wr_reg(14, 0); wr_reg(2, 0); wr_reg(4, 32'h3F);
    wr_reg(10, 32'h15); wr_reg(0, 1);
    cap[0] = 0; cyc(6);
    wr_reg(4, 32'h3F); cyc(2);
    rd_chk("R8", 4, 0);
    cap[0] = 1; addr = 11; cyc(5);
    rd_chk("R8", 4, 32'h10);
    cap[1] = 0; addr = 12; cyc(5);
    rd_chk("R8", 4, 32'h10);
    wr_reg(0, 0); cap[0] = 0; cyc(2); cap[0] = 1; addr = 11; cyc(5);
    wr_reg(0, 1);
    wr_reg(5, 32'b001); wr_reg(6, 8'h40); wr_reg(4, 32'h3F);
    addr = 4;
    for (int i = 0; i < 8; i++) begin wr_reg(4, 32'h01); cap[0] = ~cap[0]; end
    cyc(10);

    for (int i = 0; i < 15; i++) rd_chk(req_of(i), i, model_read(i));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule